// File: doc/BRIEF.md
# Direct-Sequence Spread-Spectrum Transmit Framer

This block turns a packet handed over one byte at a time into a stream of spreading chips for a 2.4 GHz low-rate personal-area radio. After the host starts a frame with a length, the block emits on its own a run of zero preamble bytes, a start-of-frame delimiter and the length byte. It then pulls the payload bytes from the host and finishes with a 16-bit CRC over that payload. Each byte goes out as two 4-bit symbols, low nibble first. Each symbol becomes a 32-chip pseudo-noise code, so every information bit costs 8 chips.

One chip leaves per chip strobe. A 16 MHz system clock divided by 8 gives 2 Mchip/s, and with 8 chips per bit that makes 250 kbit/s. A status level reports that the delimiter has gone out and stays up until the frame ends. A length that a frame cannot carry is refused with a one-cycle error pulse, and nothing is sent.

The payload input is a valid/ready stream. A byte transfers on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is raised only in the cycle in which the last chip of the byte now being spread is issued, or when nothing is loaded. The host is therefore held off for 64 chips per byte. To keep the chip stream continuous, the host must have the next byte valid by that cycle. While the host holds `in_valid`, it must keep `in_data` unchanged.

Top module: `dsss_tx_framer`

## Requirements
- R1: After reset, `busy`, `chip_valid`, `in_ready`, `sfd_sent` and `len_err` are all low, and no chip is issued until a frame is started.
- R2: A frame begins with 4 bytes of 0x00 and then the delimiter byte 0xA7. Every byte is sent as its low nibble (bits 3:0) and then its high nibble (bits 7:4).
- R3: Each nibble value s is sent as 32 chips, chip 0 first. For s = 0 the chips 0..31 are 11011001110000110101001000101110. For s from 1 to 7, chip i equals chip (i - 4s) mod 32 of the s = 0 code. For s from 8 to 15, the code is that of s - 8 with every odd-numbered chip inverted.
- R4: The byte after the delimiter equals `tx_len` as given at the start pulse.
- R5: The `tx_len - 2` payload bytes are taken through the valid/ready handshake in arrival order and sent in that order. `in_ready` is high only while the payload is being taken.
- R6: After the payload comes a CRC over the payload bytes only: polynomial x^16+x^12+x^5+1, initial value 0x0000, data bits taken LSB first, no final inversion. It is sent as the low byte and then the high byte.
- R7: During a frame, `chip_valid` is a one-cycle pulse every 8 clocks. A frame carries exactly (tx_len + 6) x 64 chips.
- R8: `sfd_sent` rises in the cycle after the chip pulse that carries the delimiter's last chip. It stays high through the frame's last chip and falls right after it.
- R9: A start with `tx_len` above 127 or below 2 gives a `len_err` pulse one cycle later. No chip is sent and `busy` stays low.
- R10: `busy` is high from the cycle after an accepted start until the cycle after the last chip. A start pulse while `busy` is high is ignored.
- R11: With `tx_len` = 2 the frame has no payload bytes, and its two CRC bytes are 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (16 MHz nominal) |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_start | input | 1 | One-cycle request to begin a frame |
| tx_len | input | 8 | Frame length byte (payload plus 2 CRC bytes), sampled with `tx_start` |
| len_err | output | 1 | One-cycle pulse: the requested length was refused |
| busy | output | 1 | A frame is in progress |
| in_valid | input | 1 | Payload byte on `in_data` is valid |
| in_data | input | 8 | Payload byte |
| in_ready | output | 1 | Block accepts the payload byte on this edge |
| chip_out | output | 1 | Current chip value, meaningful while `chip_valid` is high |
| chip_valid | output | 1 | One-cycle chip strobe |
| sfd_sent | output | 1 | Delimiter has been fully sent in the current frame |

## Verification
The assertions rely on `tx_start` being a single-cycle pulse and on the host keeping `in_valid` up with its data stable through the payload. Only then do chip pulses come exactly 8 clocks apart for the whole frame. The bench feeds every payload byte as soon as it may, so no underrun gap occurs. It raises `tx_start` only for one cycle at a time, including when it fires a start into a running frame. Lengths of 2, 5, 20 and 127 cover the empty, short and largest payloads. The values 0, 1, 128 and 255 probe the refusal path.

// File: rtl/dsss_tx_pkg.sv
package dsss_tx_pkg;

  // Code for nibble 0, chip i at bit (31 - i).
  localparam logic [31:0] BASE_CODE = 32'hD9C3522E;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_PRE, SQ_SFD, SQ_LEN, SQ_PAY, SQ_FCS_LO, SQ_FCS_HI, SQ_DRAIN
  } seq_state_e;

  // Chip idx of the code for nibble sym: rotated base, odd chips flipped for sym >= 8.
  function automatic logic pn_chip(input logic [3:0] sym, input logic [4:0] idx);
    logic [4:0] j;
    j = idx - {sym[2:0], 2'b00};
    return BASE_CODE[5'd31 - j] ^ (sym[3] & idx[0]);
  endfunction

  // Reflected CRC-16 step over one byte, LSB first.
  function automatic logic [15:0] crc16_byte(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 8; i++) begin
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 16'h8408;
    end
    return r;
  endfunction

endpackage

// File: rtl/dsss_chip_timer.sv
module dsss_chip_timer #(
  parameter int CLK_PER_CHIP = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic strobe
);
  localparam int CW = (CLK_PER_CHIP > 1) ? $clog2(CLK_PER_CHIP) : 1;

  logic [CW-1:0] cnt;

  assign strobe = (cnt == CW'(CLK_PER_CHIP - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (strobe) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe); // R7
endmodule

// File: rtl/dsss_symbol_spreader.sv
module dsss_symbol_spreader
  import dsss_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       byte_valid,
  input  logic [7:0] byte_data,
  output logic       byte_ready,
  output logic       chip_out,
  output logic       chip_valid,
  output logic       byte_done
);
  logic       loaded;
  logic [7:0] cur;
  logic       hi;
  logic [4:0] idx;
  logic       last_chip;

  assign last_chip  = loaded && strobe && hi && (idx == 5'd31);
  assign byte_ready = !loaded || last_chip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded     <= 1'b0;
      cur        <= '0;
      hi         <= 1'b0;
      idx        <= '0;
      chip_out   <= 1'b0;
      chip_valid <= 1'b0;
      byte_done  <= 1'b0;
    end else begin
      chip_valid <= 1'b0;
      byte_done  <= 1'b0;
      if (loaded && strobe) begin
        chip_out   <= pn_chip(hi ? cur[7:4] : cur[3:0], idx);
        chip_valid <= 1'b1;
        idx        <= idx + 1'b1;
        if (idx == 5'd31) begin
          hi <= !hi;
          if (hi) byte_done <= 1'b1;
        end
      end
      if (byte_ready && byte_valid) begin
        cur    <= byte_data;
        loaded <= 1'b1;
        hi     <= 1'b0;
        idx    <= '0;
      end else if (last_chip) begin
        loaded <= 1'b0;
      end
    end
  end

  AST_DONE_WITH_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done |-> chip_valid); // R7
endmodule

// File: rtl/dsss_frame_seq.sv
module dsss_frame_seq
  import dsss_tx_pkg::*;
#(
  parameter int         PRE_BYTES = 4,
  parameter logic [7:0] SFD_BYTE  = 8'hA7,
  parameter int         MAX_LEN   = 127
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] len,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  input  logic       sp_ready,
  input  logic       byte_done,
  output logic       sp_valid,
  output logic [7:0] sp_data,
  output logic       busy,
  output logic       sfd_sent,
  output logic       len_err
);
  localparam int PW = (PRE_BYTES > 1) ? $clog2(PRE_BYTES) : 1;
  localparam int DW = $clog2(PRE_BYTES + MAX_LEN + 3) + 1;

  seq_state_e    state;
  logic [PW-1:0] pre_cnt;
  logic [7:0]    len_q;
  logic [7:0]    left;
  logic [15:0]   crc;
  logic [DW-1:0] done_cnt;
  logic [DW-1:0] last_idx;
  logic          take;

  assign last_idx = DW'(len_q) + DW'(PRE_BYTES + 1);

  always_comb begin
    sp_valid = 1'b0;
    sp_data  = 8'h00;
    case (state)
      SQ_PRE:    sp_valid = 1'b1;
      SQ_SFD:    begin sp_valid = 1'b1; sp_data = SFD_BYTE;   end
      SQ_LEN:    begin sp_valid = 1'b1; sp_data = len_q;      end
      SQ_PAY:    begin sp_valid = in_valid; sp_data = in_data; end
      SQ_FCS_LO: begin sp_valid = 1'b1; sp_data = crc[7:0];   end
      SQ_FCS_HI: begin sp_valid = 1'b1; sp_data = crc[15:8];  end
      default:   ;
    endcase
  end

  assign take     = sp_valid && sp_ready;
  assign in_ready = (state == SQ_PAY) && sp_ready;
  assign busy     = (state != SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SQ_IDLE;
      pre_cnt  <= '0;
      len_q    <= '0;
      left     <= '0;
      crc      <= '0;
      done_cnt <= '0;
      sfd_sent <= 1'b0;
      len_err  <= 1'b0;
    end else begin
      len_err <= 1'b0;
      if (byte_done) begin
        done_cnt <= done_cnt + 1'b1;
        if (done_cnt == DW'(PRE_BYTES)) sfd_sent <= 1'b1;
      end
      case (state)
        SQ_IDLE: if (start) begin
          if (len > 8'(MAX_LEN) || len < 8'd2) begin
            len_err <= 1'b1;
          end else begin
            len_q    <= len;
            left     <= len - 8'd2;
            crc      <= '0;
            pre_cnt  <= '0;
            done_cnt <= '0;
            state    <= SQ_PRE;
          end
        end
        SQ_PRE: if (take) begin
          pre_cnt <= pre_cnt + 1'b1;
          if (pre_cnt == PW'(PRE_BYTES - 1)) state <= SQ_SFD;
        end
        SQ_SFD: if (take) state <= SQ_LEN;
        SQ_LEN: if (take) state <= (left == 8'd0) ? SQ_FCS_LO : SQ_PAY;
        SQ_PAY: if (take) begin
          crc  <= crc16_byte(crc, in_data);
          left <= left - 8'd1;
          if (left == 8'd1) state <= SQ_FCS_LO;
        end
        SQ_FCS_LO: if (take) state <= SQ_FCS_HI;
        SQ_FCS_HI: if (take) state <= SQ_DRAIN;
        SQ_DRAIN: if (byte_done && done_cnt == last_idx) begin
          state    <= SQ_IDLE;
          sfd_sent <= 1'b0;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  AST_READY_IN_PAYLOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> busy); // R5
  AST_ERR_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> ($past(start) && !busy)); // R9
endmodule

// File: rtl/dsss_tx_framer.sv
module dsss_tx_framer
  import dsss_tx_pkg::*;
#(
  parameter int         CLK_PER_CHIP = 8,
  parameter int         PRE_BYTES    = 4,
  parameter logic [7:0] SFD_BYTE     = 8'hA7,
  parameter int         MAX_LEN      = 127
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_start,
  input  logic [7:0] tx_len,
  output logic       len_err,
  output logic       busy,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       chip_out,
  output logic       chip_valid,
  output logic       sfd_sent
);
  localparam int GW = $clog2(CLK_PER_CHIP + 1);

  logic       strobe;
  logic       sp_valid;
  logic       sp_ready;
  logic [7:0] sp_data;
  logic       byte_done;

  dsss_chip_timer #(.CLK_PER_CHIP(CLK_PER_CHIP)) i_timer (
    .clk(clk), .rst_n(rst_n), .strobe(strobe)
  );

  dsss_frame_seq #(.PRE_BYTES(PRE_BYTES), .SFD_BYTE(SFD_BYTE), .MAX_LEN(MAX_LEN)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(tx_start), .len(tx_len),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sp_ready(sp_ready), .byte_done(byte_done), .sp_valid(sp_valid), .sp_data(sp_data),
    .busy(busy), .sfd_sent(sfd_sent), .len_err(len_err)
  );

  dsss_symbol_spreader i_spread (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .byte_valid(sp_valid), .byte_data(sp_data), .byte_ready(sp_ready),
    .chip_out(chip_out), .chip_valid(chip_valid), .byte_done(byte_done)
  );

  // Spacing watch: cycles since the previous chip pulse, saturating.
  logic [GW-1:0] gap;
  logic          seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (chip_valid) begin
      gap  <= GW'(1);
      seen <= 1'b1;
    end else if (gap != GW'(CLK_PER_CHIP)) begin
      gap <= gap + 1'b1;
    end
  end

  AST_CHIP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (chip_valid && seen) |-> (gap >= GW'(CLK_PER_CHIP))); // R7
  AST_CHIP_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    chip_valid |-> busy); // R10
  AST_SFD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sfd_sent |-> busy); // R8
  AST_SFD_RISE_AFTER_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sfd_sent) |-> $past(chip_valid)); // R8
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> !chip_valid); // R9
endmodule

// File: tb/test_dsss_tx_framer.sv
module test_dsss_tx_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_start = 1'b0;
  logic [7:0] tx_len = 8'd0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       len_err, busy, in_ready, chip_out, chip_valid, sfd_sent;

  always #4 clk = ~clk;

  dsss_tx_framer i_dsss_tx_framer (
    .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_len(tx_len),
    .len_err(len_err), .busy(busy), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .chip_out(chip_out), .chip_valid(chip_valid),
    .sfd_sent(sfd_sent)
  );

  int checks = 0;
  int fails  = 0;
  bit done_flag = 0;

  logic [31:0] code_tbl [16];
  initial begin
    code_tbl[0]  = 32'b11011001110000110101001000101110;
    code_tbl[1]  = 32'b11101101100111000011010100100010;
    code_tbl[2]  = 32'b00101110110110011100001101010010;
    code_tbl[3]  = 32'b00100010111011011001110000110101;
    code_tbl[4]  = 32'b01010010001011101101100111000011;
    code_tbl[5]  = 32'b00110101001000101110110110011100;
    code_tbl[6]  = 32'b11000011010100100010111011011001;
    code_tbl[7]  = 32'b10011100001101010010001011101101;
    code_tbl[8]  = 32'b10001100100101100000011101111011;
    code_tbl[9]  = 32'b10111000110010010110000001110111;
    code_tbl[10] = 32'b01111011100011001001011000000111;
    code_tbl[11] = 32'b01110111101110001100100101100000;
    code_tbl[12] = 32'b00000111011110111000110010010110;
    code_tbl[13] = 32'b01100000011101111011100011001001;
    code_tbl[14] = 32'b10010110000001110111101110001100;
    code_tbl[15] = 32'b11001001011000000111011110111000;
  end

  // Stimulus and capture state.
  logic [7:0] pay [0:127];
  int         npay = 0;
  int         pidx = 0;
  bit         feeding = 0;
  bit         take_next = 0;
  int         hs_count = 0;
  bit         rec_en = 0;
  bit         chips [0:9000];
  bit         sfd_at [0:9000];
  int         nchips = 0;
  int         gap_bad = 0;
  longint     cyc = 0;
  longint     last_cyc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (take_next) begin
      pidx++;
      hs_count++;
      take_next = 0;
    end
    in_valid = feeding && (pidx < npay);
    in_data  = (pidx < npay) ? pay[pidx] : 8'h00;
    if (in_valid && in_ready) take_next = 1;
    if (rec_en && chip_valid) begin
      chips[nchips]  = chip_out;
      sfd_at[nchips] = sfd_sent;
      if (nchips > 0 && (cyc - last_cyc) != 8) gap_bad++;
      last_cyc = cyc;
      nchips++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(input int n);
    logic [15:0] c = 16'h0000;
    for (int b = 0; b < n; b++)
      for (int i = 0; i < 8; i++) begin
        if (c[0] ^ pay[b][i]) c = (c >> 1) ^ 16'h8408;
        else                  c = c >> 1;
      end
    return c;
  endfunction

  function automatic logic [7:0] exp_byte(input int k, input int len, input logic [15:0] crc);
    if (k < 4) return 8'h00;
    if (k == 4) return 8'hA7;
    if (k == 5) return len[7:0];
    if (k < 6 + len - 2) return pay[k - 6];
    if (k == 6 + len - 2) return crc[7:0];
    return crc[15:8];
  endfunction

  // Compare chips of bytes [b0, b1) with the expected byte stream.
  task automatic cmp_bytes(input int b0, input int b1, input int len,
                           input logic [15:0] crc, input string req);
    int bad = -1;
    int act = 0;
    int exp = 0;
    for (int c = b0 * 64; c < b1 * 64; c++) begin
      logic [7:0] eb;
      logic [3:0] sym;
      logic       e;
      eb  = exp_byte(c / 64, len, crc);
      sym = ((c % 64) < 32) ? eb[3:0] : eb[7:4];
      e   = code_tbl[sym][31 - (c % 32)];
      if (bad < 0 && chips[c] !== e) begin
        bad = c; act = chips[c]; exp = e;
      end
    end
    check(bad < 0, req, $sformatf("chip stream, first mismatch at chip %0d", bad), act, exp);
  endtask

  task automatic run_frame(input int len, input int seed, input bit inject);
    logic [15:0] crc;
    int total;
    npay = len - 2;
    for (int k = 0; k < npay; k++) pay[k] = 8'((seed * (k + 3) * 37 + k * 11) & 8'hFF);
    pidx = 0; hs_count = 0; nchips = 0; gap_bad = 0; take_next = 0;
    feeding = 1; rec_en = 1;
    @(negedge clk); tx_start = 1'b1; tx_len = 8'(len);
    @(negedge clk); tx_start = 1'b0;
    check(busy === 1'b1, "R10", "busy after start", busy, 1);
    if (inject) begin
      repeat (1500) @(negedge clk);
      tx_start = 1'b1; tx_len = 8'd9;
      @(negedge clk); tx_start = 1'b0;
      check(len_err === 1'b0, "R10", "no error on start while busy", len_err, 0);
    end
    while (busy) begin
      if (in_ready && pidx >= npay) check(0, "R5", "in_ready outside payload", 1, 0);
      @(negedge clk);
    end
    check(sfd_sent === 1'b0, "R8", "sfd_sent low after frame", sfd_sent, 0);
    repeat (20) @(negedge clk);
    feeding = 0; rec_en = 0;
    crc   = ref_crc(npay);
    total = (len + 6) * 64;
    check(nchips == total, "R7", "chip count", nchips, total);
    check(gap_bad == 0, "R7", "chip pulses 8 clocks apart", gap_bad, 0);
    check(hs_count == npay, "R5", "payload handshakes", hs_count, npay);
    if (nchips == total) begin
      cmp_bytes(0, 5, len, crc, "R2 R3");
      cmp_bytes(5, 6, len, crc, "R4");
      if (npay > 0) cmp_bytes(6, 6 + npay, len, crc, "R3 R5");
      cmp_bytes(6 + npay, 8 + npay, len, crc, len == 2 ? "R6 R11" : "R6");
      check(sfd_at[319] == 1'b0, "R8", "sfd_sent at last delimiter chip", sfd_at[319], 0);
      check(sfd_at[320] == 1'b1, "R8", "sfd_sent at first length chip", sfd_at[320], 1);
      check(sfd_at[total-1] == 1'b1, "R8", "sfd_sent at last chip", sfd_at[total-1], 1);
    end
  endtask

  task automatic reject_len(input int len);
    int seen_chips = 0;
    @(negedge clk); tx_start = 1'b1; tx_len = 8'(len);
    @(negedge clk); tx_start = 1'b0;
    check(len_err === 1'b1, "R9", $sformatf("len_err for length %0d", len), len_err, 1);
    check(busy === 1'b0, "R9", "busy stays low on refusal", busy, 0);
    @(negedge clk);
    check(len_err === 1'b0, "R9", "len_err is one cycle", len_err, 0);
    repeat (40) begin
      if (chip_valid) seen_chips++;
      @(negedge clk);
    end
    check(seen_chips == 0, "R9", "no chips after refusal", seen_chips, 0);
  endtask

  task automatic test_reset;
    int seen_chips = 0;
    repeat (40) begin
      @(negedge clk);
      if (chip_valid) seen_chips++;
    end
    check(busy === 1'b0 && in_ready === 1'b0 && sfd_sent === 1'b0 && len_err === 1'b0,
          "R1", "outputs low after reset",
          {busy, in_ready, sfd_sent, len_err}, 0);
    check(seen_chips == 0, "R1", "no chips while idle", seen_chips, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    run_frame(5, 3, 0);
    run_frame(2, 1, 0);
    reject_len(128);
    reject_len(1);
    reject_len(0);
    reject_len(255);
    run_frame(20, 7, 1);
    run_frame(127, 5, 0);
    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule